// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block serialises parallel audio sample words onto up to four data lines in time-division-multiplexed frames. A bit-clock enable (`bclkEn`) pulses twice per serial bit. The first pulse of each pair launches the next data bit and the frame-sync level. The second pulse completes the bit period on the bit-clock output. Inside the frame, the slot count, slot width and sample width are set at run time. The frame sync is either generated internally or recovered from an external edge.

Independent controls set the frame-sync length (one bit or a whole slot), its position (one bit early or aligned with the first data bit), the sync polarity and the bit-clock polarity. With these controls the same engine produces I2S, left-justified, right-justified and both DSP timings. Samples arrive over a ready/valid interface, one word per line for each enabled slot. Pulsed status outputs report underruns and the end of a frame, and a level output shows whether the current slot index is even.

Top module: `tdm_tx`

## Requirements
- R1: Each serial bit takes two `bclkEn` pulses. On the first pulse (the launch), the data lines and `fsOut` update, MSB first, and `bclkOut` goes to the level of `cfgBclkInv`. On the second pulse, `bclkOut` goes to the opposite level. Without a pulse, the data lines hold.
- R2: The frame sync lasts one bit when `cfgFsWord`=0, and one full slot (`cfgSlotWidth` bits) when `cfgFsWord`=1.
- R3: With `cfgFsEarly`=1 the sync becomes active one bit before the first data bit of slot 0. With `cfgFsEarly`=0 it starts together with that bit.
- R4: `fsOut` is the active-high sync XOR `cfgFsInv`. `bclkOut` is inverted by `cfgBclkInv`.
- R5: A slot carries `cfgSlotWidth` bits, and the low `cfgWordWidth` bits of the sample word are sent MSB first. With `cfgAlignEnd`=0 the sample starts at the first bit of the slot and the trailing bits are zero. With `cfgAlignEnd`=1 the sample ends at the last bit of the slot and the leading bits are zero.
- R6: A slot whose bit in `cfgSlotMask` is 0 (bit i for slot i) drives zeros on every line and raises no `sRdy`, so it consumes no input word.
- R7: Line g carries bits [g*24 +: 24] of `sData`. Lines with index at or above `cfgLines` always drive zero.
- R8: In network mode (`cfgNetwork`=1) a frame has `cfgSlots` slots. In normal mode a frame has exactly one slot, whatever the value of `cfgSlots`.
- R9: If `sRdy` is high while `sVal` is low, that slot is sent as zeros on all lines, the word is not consumed, and `underrun` pulses for one cycle after the launch.
- R10: `lastSlot` pulses for one cycle after the launch of the final bit of the final slot. `evenSlot` is high while the slot being sent has an even index.
- R11: With `cfgMaster`=0, a launch that finds the external sync (after polarity) newly active restarts the frame. In aligned mode that bit becomes bit 0 of slot 0. In early mode it becomes the final bit of the frame.
- R12: Under reset the data lines are low, the sync is inactive, the status outputs are low, and the raw bit clock sits at the level opposite the launch level.
- R13: `sRdy` is high only during a launch that starts an enabled slot. At that clock edge all lines take their words, and only when `sVal` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bclkEn | input | 1 | Half-bit tick, two per serial bit |
| cfgMaster | input | 1 | 1: generate frame sync, 0: follow fsIn |
| cfgFsWord | input | 1 | Sync length: 0 one bit, 1 one slot |
| cfgFsEarly | input | 1 | Sync one bit before data when 1 |
| cfgFsInv | input | 1 | Invert sync polarity |
| cfgBclkInv | input | 1 | Invert bit-clock polarity |
| cfgNetwork | input | 1 | 1: multi-slot frame, 0: one slot |
| cfgSlots | input | 4 | Slots per frame in network mode (1..8) |
| cfgSlotWidth | input | 6 | Bits per slot (1..32) |
| cfgWordWidth | input | 5 | Sample bits per slot (1..24, not above slot width) |
| cfgAlignEnd | input | 1 | Align sample to end of slot when 1 |
| cfgSlotMask | input | 8 | Per-slot enable |
| cfgLines | input | 3 | Number of active data lines |
| sVal | input | 1 | Sample words valid |
| sData | input | 96 | One 24-bit word per line |
| sRdy | output | 1 | Words taken at this edge |
| fsIn | input | 1 | External frame sync |
| fsOut | output | 1 | Frame sync output |
| bclkOut | output | 1 | Bit-clock output |
| sdOut | output | 4 | Serial data lines |
| underrun | output | 1 | Underrun pulse |
| lastSlot | output | 1 | End-of-frame pulse |
| evenSlot | output | 1 | Current slot index is even |

## Verification
The bound checker watches properties that hold on every cycle. It confirms that words are taken only on a bit tick, that a missing sample produces zeros and a one-cycle underrun pulse, that data holds between ticks, that the bit clock toggles on every tick, and that the status pulses are single-cycle. The following properties depend on the frame position and on the configured format, so only the bench scenarios can show them: sync length and position, the polarity, the sample placement and padding inside slots, mask skipping, the line count, the normal-mode slot count and the slave realignment to an external sync edge. The bench compares these bit by bit against a model of the frame for each timing variant.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  // strobes from the frame control to the serialiser
  typedef struct packed {
    logic launch;  // bit-launch tick
    logic load;    // first bit of a slot
    logic fill;    // slot takes fresh sample words
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_tx_ctrl.sv
module tdm_tx_ctrl
  import tdm_tx_pkg::*;
#(
  parameter int SLOTS_MAX  = 8,
  parameter int SLOT_W_MAX = 32,
  localparam int SC_W = $clog2(SLOTS_MAX + 1),
  localparam int SI_W = $clog2(SLOTS_MAX),
  localparam int BW_W = $clog2(SLOT_W_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bclkEn,
  input  logic             cfgMaster,
  input  logic             cfgFsWord,
  input  logic             cfgFsEarly,
  input  logic             cfgFsInv,
  input  logic             cfgBclkInv,
  input  logic             cfgNetwork,
  input  logic [SC_W-1:0]  cfgSlots,
  input  logic [BW_W-1:0]  cfgSlotWidth,
  input  logic [SLOTS_MAX-1:0] cfgSlotMask,
  input  logic             sVal,
  output logic             sRdy,
  input  logic             fsIn,
  output logic             fsOut,
  output logic             bclkOut,
  output logic             underrun,
  output logic             lastSlot,
  output logic             evenSlot,
  output tdmStrobe_t       ctl
);
  logic            phase, first, fsPrev, fsRaw, bclkRaw;
  logic            underrunR, lastR, evenR;
  logic [SC_W-1:0] effSlots, lastSlotIdx, slotIdx, nSlot;
  logic [BW_W-1:0] lastBit, bitIdx, nBit;
  logic            launch, fsAct, syncEdge, fsNew, slotOn, isLast, loadSlot;

  assign effSlots    = cfgNetwork ? cfgSlots : SC_W'(1);
  assign lastSlotIdx = effSlots - SC_W'(1);
  assign lastBit     = cfgSlotWidth - BW_W'(1);
  assign launch      = bclkEn && !phase;
  assign fsAct       = fsIn ^ cfgFsInv;
  assign syncEdge    = !cfgMaster && fsAct && !fsPrev;

  // position of the bit launched at this tick
  always_comb begin
    if (syncEdge) begin
      nSlot = cfgFsEarly ? lastSlotIdx : '0;
      nBit  = cfgFsEarly ? lastBit : '0;
    end else if (first || (bitIdx >= lastBit && slotIdx >= lastSlotIdx)) begin
      nSlot = '0;
      nBit  = '0;
    end else if (bitIdx >= lastBit) begin
      nSlot = slotIdx + SC_W'(1);
      nBit  = '0;
    end else begin
      nSlot = slotIdx;
      nBit  = bitIdx + BW_W'(1);
    end
  end

  always_comb begin
    if (cfgFsEarly)
      fsNew = (nSlot == lastSlotIdx && nBit == lastBit) ||
              (nSlot == '0 && cfgFsWord && nBit != lastBit);
    else
      fsNew = (nSlot == '0) && (cfgFsWord || nBit == '0);
  end

  assign slotOn   = (nSlot < SC_W'(SLOTS_MAX)) ? cfgSlotMask[nSlot[SI_W-1:0]] : 1'b0;
  assign isLast   = (nSlot == lastSlotIdx) && (nBit == lastBit);
  assign loadSlot = launch && (nBit == '0);
  assign sRdy     = loadSlot && slotOn;

  assign ctl.launch = launch;
  assign ctl.load   = loadSlot;
  assign ctl.fill   = sRdy && sVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 1'b0;
      first     <= 1'b1;
      slotIdx   <= '0;
      bitIdx    <= '0;
      fsPrev    <= 1'b0;
      fsRaw     <= 1'b0;
      bclkRaw   <= 1'b1;
      underrunR <= 1'b0;
      lastR     <= 1'b0;
      evenR     <= 1'b0;
    end else begin
      if (bclkEn) begin
        phase   <= ~phase;
        bclkRaw <= !launch;
      end
      if (launch) begin
        first     <= 1'b0;
        slotIdx   <= nSlot;
        bitIdx    <= nBit;
        fsPrev    <= fsAct;
        fsRaw     <= fsNew;
        underrunR <= sRdy && !sVal;
        lastR     <= isLast;
        evenR     <= !nSlot[0];
      end else begin
        underrunR <= 1'b0;
        lastR     <= 1'b0;
      end
    end
  end

  assign fsOut    = fsRaw ^ cfgFsInv;
  assign bclkOut  = bclkRaw ^ cfgBclkInv;
  assign underrun = underrunR;
  assign lastSlot = lastR;
  assign evenSlot = evenR;
endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath
  import tdm_tx_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int SLOT_W_MAX = 32,
  parameter int WORD_MAX   = 24,
  localparam int BW_W = $clog2(SLOT_W_MAX + 1),
  localparam int WW_W = $clog2(WORD_MAX + 1),
  localparam int LN_W = $clog2(LINES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tdmStrobe_t                ctl,
  input  logic [LINES*WORD_MAX-1:0] sData,
  input  logic [LN_W-1:0]           cfgLines,
  input  logic [BW_W-1:0]           cfgSlotWidth,
  input  logic [WW_W-1:0]           cfgWordWidth,
  input  logic                      cfgAlignEnd,
  output logic [LINES-1:0]          sdOut
);
  logic [BW_W-1:0] shAmt;
  assign shAmt = cfgAlignEnd ? BW_W'(SLOT_W_MAX) - cfgSlotWidth
                             : BW_W'(SLOT_W_MAX) - BW_W'(cfgWordWidth);

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [WORD_MAX-1:0]   wordRaw, wordMask;
    logic [SLOT_W_MAX-1:0] wordExt, loaded, shReg;
    logic                  lineOn, sdR;

    assign wordRaw  = sData[g*WORD_MAX +: WORD_MAX];
    assign wordMask = wordRaw & ~({WORD_MAX{1'b1}} << cfgWordWidth);
    assign wordExt  = SLOT_W_MAX'(wordMask);
    assign lineOn   = LN_W'(g) < cfgLines;
    // sample placed so that its MSB is the first bit it occupies in the slot
    assign loaded   = (ctl.fill && lineOn) ? (wordExt << shAmt) : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg <= '0;
        sdR   <= 1'b0;
      end else if (ctl.launch) begin
        if (ctl.load) begin
          sdR   <= loaded[SLOT_W_MAX-1];
          shReg <= loaded << 1;
        end else begin
          sdR   <= shReg[SLOT_W_MAX-1];
          shReg <= shReg << 1;
        end
      end
    end

    assign sdOut[g] = sdR;
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int SLOTS_MAX  = 8,
  parameter int SLOT_W_MAX = 32,
  parameter int WORD_MAX   = 24,
  localparam int SC_W = $clog2(SLOTS_MAX + 1),
  localparam int BW_W = $clog2(SLOT_W_MAX + 1),
  localparam int WW_W = $clog2(WORD_MAX + 1),
  localparam int LN_W = $clog2(LINES + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      bclkEn,
  input  logic                      cfgMaster,
  input  logic                      cfgFsWord,
  input  logic                      cfgFsEarly,
  input  logic                      cfgFsInv,
  input  logic                      cfgBclkInv,
  input  logic                      cfgNetwork,
  input  logic [SC_W-1:0]           cfgSlots,
  input  logic [BW_W-1:0]           cfgSlotWidth,
  input  logic [WW_W-1:0]           cfgWordWidth,
  input  logic                      cfgAlignEnd,
  input  logic [SLOTS_MAX-1:0]      cfgSlotMask,
  input  logic [LN_W-1:0]           cfgLines,
  input  logic                      sVal,
  input  logic [LINES*WORD_MAX-1:0] sData,
  output logic                      sRdy,
  input  logic                      fsIn,
  output logic                      fsOut,
  output logic                      bclkOut,
  output logic [LINES-1:0]          sdOut,
  output logic                      underrun,
  output logic                      lastSlot,
  output logic                      evenSlot
);
  tdmStrobe_t ctl;

  tdm_tx_ctrl #(.SLOTS_MAX(SLOTS_MAX), .SLOT_W_MAX(SLOT_W_MAX)) u_ctrl (
    .clk, .rstN, .bclkEn, .cfgMaster, .cfgFsWord, .cfgFsEarly, .cfgFsInv,
    .cfgBclkInv, .cfgNetwork, .cfgSlots, .cfgSlotWidth, .cfgSlotMask,
    .sVal, .sRdy, .fsIn, .fsOut, .bclkOut, .underrun, .lastSlot, .evenSlot,
    .ctl
  );

  tdm_tx_datapath #(.LINES(LINES), .SLOT_W_MAX(SLOT_W_MAX), .WORD_MAX(WORD_MAX)) u_dp (
    .clk, .rstN, .ctl, .sData, .cfgLines, .cfgSlotWidth, .cfgWordWidth,
    .cfgAlignEnd, .sdOut
  );
endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             bclkEn,
  input logic             sVal,
  input logic             sRdy,
  input logic [LINES-1:0] sdOut,
  input logic             bclkOut,
  input logic             underrun,
  input logic             lastSlot
);
  a_r13_ready_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    sRdy |-> bclkEn);
  a_r9_underrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    (sRdy && !sVal) |=> underrun);
  a_r9_zero_slot: assert property (@(posedge clk) disable iff (!rstN)
    (sRdy && !sVal) |=> (sdOut == '0));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun);
  a_r1_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    !bclkEn |=> $stable(sdOut));
  a_r1_bclk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    bclkEn |=> !$stable(bclkOut));
  a_r10_last_pulse: assert property (@(posedge clk) disable iff (!rstN)
    lastSlot |=> !lastSlot);
endmodule

bind tdm_tx tdm_tx_checker #(.LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .bclkEn(bclkEn), .sVal(sVal), .sRdy(sRdy),
  .sdOut(sdOut), .bclkOut(bclkOut), .underrun(underrun), .lastSlot(lastSlot)
);

// File: tb/tdm_tx_test.sv
module tdm_tx_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bclkEn = 1'b0;
  logic        cfgMaster = 1'b1, cfgFsWord = 1'b0, cfgFsEarly = 1'b0, cfgFsInv = 1'b1;
  logic        cfgBclkInv = 1'b0, cfgNetwork = 1'b1, cfgAlignEnd = 1'b0;
  logic [3:0]  cfgSlots = 4'd2;
  logic [5:0]  cfgSlotWidth = 6'd8;
  logic [4:0]  cfgWordWidth = 5'd8;
  logic [7:0]  cfgSlotMask = 8'h03;
  logic [2:0]  cfgLines = 3'd2;
  logic        sVal = 1'b1, fsIn = 1'b0;
  logic [95:0] sData;
  logic        sRdy, fsOut, bclkOut, underrun, lastSlot, evenSlot;
  logic [3:0]  sdOut;
  int          cnt = 0;
  int          checks = 0, failures = 0;

  always #5 clk = ~clk;

  function automatic logic [23:0] f0(int n);
    return 24'(32'h00A53C96 ^ (n * 32'h0013579B));
  endfunction
  function automatic logic [23:0] f1(int n);
    return 24'(32'h003CC369 + n * 32'h000B7E15);
  endfunction

  always_comb sData = {f1(cnt + 3), f0(cnt + 7), f1(cnt), f0(cnt)};

  tdm_tx uut (
    .clk, .rstN, .bclkEn, .cfgMaster, .cfgFsWord, .cfgFsEarly, .cfgFsInv,
    .cfgBclkInv, .cfgNetwork, .cfgSlots, .cfgSlotWidth, .cfgWordWidth,
    .cfgAlignEnd, .cfgSlotMask, .cfgLines, .sVal, .sData, .sRdy, .fsIn,
    .fsOut, .bclkOut, .sdOut, .underrun, .lastSlot, .evenSlot
  );

  // fsWord, early, inv, alignEnd, network, slots[4], slotW[6], wordW[5], mask[8]
  localparam logic [27:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 6'd8,  5'd8, 8'h03},  // I2S
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 6'd8,  5'd6, 8'h03},  // left-justified
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd2, 6'd8,  5'd6, 8'h03},  // right-justified
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 6'd6,  5'd4, 8'h0B},  // DSP early
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 6'd5,  5'd5, 8'h05},  // DSP aligned
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4, 6'd10, 5'd7, 8'h01}   // normal mode
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic bitOf(logic [23:0] w, int b, int sw, int ww, bit endA);
    int pad = endA ? sw - ww : 0;
    if (b < pad || b >= pad + ww) return 1'b0;
    return w[ww - 1 - (b - pad)];
  endfunction

  task automatic launchBit(output logic rdy);
    @(negedge clk); bclkEn = 1'b1;
    #1 rdy = sRdy;
    @(negedge clk); bclkEn = 1'b0;
    if (rdy && sVal) cnt++;
  endtask

  task automatic secondHalf();
    @(negedge clk); bclkEn = 1'b1;
    @(negedge clk); bclkEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cnt = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic rdy;
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(sdOut == 4'h0, "R12 sdOut", 32'(sdOut), 0);
    chk(fsOut == 1'b1, "R12 fsOut inactive", 32'(fsOut), 1);
    chk(bclkOut == 1'b1, "R12 bclkOut", 32'(bclkOut), 1);
    chk({underrun, lastSlot, evenSlot} == 3'b000, "R12 status", 32'({underrun, lastSlot, evenSlot}), 0);
    chk(sRdy == 1'b0, "R12 sRdy", 32'(sRdy), 0);

    // table walk over the timing variants
    for (int v = 0; v < 6; v++) begin
      int effS, fb, fsLen, curN;
      rstN = 1'b0;
      {cfgFsWord, cfgFsEarly, cfgFsInv, cfgAlignEnd, cfgNetwork, cfgSlots,
       cfgSlotWidth, cfgWordWidth, cfgSlotMask} = VEC[v];
      cfgMaster = 1'b1; cfgLines = 3'd2; cfgBclkInv = 1'b0; sVal = 1'b1; fsIn = 1'b0;
      doReset();
      effS  = cfgNetwork ? int'(cfgSlots) : 1;
      fb    = effS * int'(cfgSlotWidth);
      fsLen = cfgFsWord ? int'(cfgSlotWidth) : 1;
      curN  = 0;
      for (int k = 0; k < 2 * fb; k++) begin
        int p, s, b, idx;
        logic en, expFs;
        p = k % fb; s = p / int'(cfgSlotWidth); b = p % int'(cfgSlotWidth);
        en = cfgSlotMask[s];
        if (b == 0) curN = cnt;
        launchBit(rdy);
        chk(rdy == (en && b == 0), "R6 R13 sRdy", 32'(rdy), 32'(en && b == 0));
        chk(sdOut[0] == (en && bitOf(f0(curN), b, int'(cfgSlotWidth), int'(cfgWordWidth), cfgAlignEnd)),
            "R1 R5 R6 line0", 32'(sdOut[0]),
            32'(en && bitOf(f0(curN), b, int'(cfgSlotWidth), int'(cfgWordWidth), cfgAlignEnd)));
        chk(sdOut[1] == (en && bitOf(f1(curN), b, int'(cfgSlotWidth), int'(cfgWordWidth), cfgAlignEnd)),
            "R5 R6 line1", 32'(sdOut[1]),
            32'(en && bitOf(f1(curN), b, int'(cfgSlotWidth), int'(cfgWordWidth), cfgAlignEnd)));
        chk(sdOut[3:2] == 2'b00, "R7 idle lines", 32'(sdOut[3:2]), 0);
        idx = cfgFsEarly ? (p + 1) % fb : p;
        expFs = (idx < fsLen) ^ cfgFsInv;
        chk(fsOut == expFs, "R2 R3 R4 R8 fsOut", 32'(fsOut), 32'(expFs));
        if (k == 0) chk(bclkOut == 1'b0, "R1 bclk launch level", 32'(bclkOut), 0);
        secondHalf();
        if (k == 0) chk(bclkOut == 1'b1, "R1 bclk second level", 32'(bclkOut), 1);
      end
    end

    // underrun, status flags, inverted bit clock
    rstN = 1'b0;
    cfgMaster = 1'b1; cfgFsWord = 1'b1; cfgFsEarly = 1'b0; cfgFsInv = 1'b0;
    cfgNetwork = 1'b1; cfgSlots = 4'd2; cfgSlotWidth = 6'd8; cfgWordWidth = 5'd8;
    cfgAlignEnd = 1'b0; cfgSlotMask = 8'h03; cfgLines = 3'd2; cfgBclkInv = 1'b1;
    doReset();
    for (int k = 0; k < 16; k++) begin
      sVal = (k != 0);
      launchBit(rdy);
      if (k == 0) begin
        chk(underrun == 1'b1, "R9 underrun pulse", 32'(underrun), 1);
        chk(bclkOut == 1'b1, "R4 inverted bclk launch", 32'(bclkOut), 1);
        chk(evenSlot == 1'b1, "R10 even slot0", 32'(evenSlot), 1);
      end
      if (k < 8) chk(sdOut == 4'h0, "R9 zero slot", 32'(sdOut), 0);
      else chk(sdOut[0] == f0(0)[15 - k], "R9 word kept", 32'(sdOut[0]), 32'(f0(0)[15 - k]));
      if (k == 8) chk(evenSlot == 1'b0, "R10 odd slot1", 32'(evenSlot), 0);
      if (k == 14) chk(lastSlot == 1'b0, "R10 not last", 32'(lastSlot), 0);
      if (k == 15) chk(lastSlot == 1'b1, "R10 last bit", 32'(lastSlot), 1);
      secondHalf();
      if (k == 0) begin
        chk(underrun == 1'b0, "R9 underrun cleared", 32'(underrun), 0);
        chk(bclkOut == 1'b0, "R4 inverted bclk second", 32'(bclkOut), 0);
      end
    end

    // one active line only
    rstN = 1'b0; cfgLines = 3'd1; cfgBclkInv = 1'b0; sVal = 1'b1;
    doReset();
    for (int k = 0; k < 8; k++) begin
      launchBit(rdy);
      chk(sdOut[3:1] == 3'b000, "R7 single line", 32'(sdOut[3:1]), 0);
      chk(sdOut[0] == f0(0)[7 - k], "R7 line0 data", 32'(sdOut[0]), 32'(f0(0)[7 - k]));
      secondHalf();
    end

    // slave mode: external sync restarts frame (one-bit, aligned)
    rstN = 1'b0;
    cfgMaster = 1'b0; cfgFsWord = 1'b0; cfgFsEarly = 1'b0; cfgFsInv = 1'b0;
    cfgLines = 3'd2; fsIn = 1'b0;
    doReset();
    for (int k = 0; k < 3; k++) begin
      launchBit(rdy);
      secondHalf();
    end
    fsIn = 1'b1;
    launchBit(rdy);
    fsIn = 1'b0;
    chk(rdy == 1'b1, "R11 restart takes word", 32'(rdy), 1);
    chk(sdOut[0] == f0(1)[7], "R11 restart msb", 32'(sdOut[0]), 32'(f0(1)[7]));
    chk(fsOut == 1'b1, "R11 sync tracked", 32'(fsOut), 1);
    secondHalf();
    for (int b = 1; b < 8; b++) begin
      launchBit(rdy);
      chk(sdOut[0] == f0(1)[7 - b], "R11 slot bits", 32'(sdOut[0]), 32'(f0(1)[7 - b]));
      secondHalf();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule